// File: doc/BRIEF.md
# Two-wire serial EEPROM slave protocol engine

This block is the bus-facing half of a 512-byte serial EEPROM. It runs on a fast system clock and oversamples the raw two-wire clock and data lines through two-flop synchronizers. It finds START and STOP conditions and shifts in the device select byte, the word address and the write data. It acknowledges or refuses each byte by pulling the data line low through an open-drain enable. It also shifts out read data, most significant bit first, for current-address, random and sequential reads.

The engine owns the 9-bit byte address counter. Toward the memory and the page-programming logic it offers a combinational read port, a one-cycle byte-write strobe carrying address and data, and a one-cycle STOP event. It takes a busy input, which tells it that an internal write cycle is running. Noise filtering, clock stretching and arbitration belong elsewhere.

Top module: `eeprom_bus_slave`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A START at any point restarts byte reception with the data line released. A STOP returns the engine to idle and pulses `stop_o` for one cycle.
- R2: Out of reset, and in idle before a START, `sda_oe_o` stays low whatever SCL and SDA do.
- R3: The first byte after a START matches only if bits [7:4] equal 1010 and bits [3:2] equal `strap_i[1:0]`. Bit 1 becomes address bit 8, and bit 0 selects a read (1) or a write (0). On a mismatch the byte is not acknowledged and the engine ignores the bus until the next START.
- R4: After each accepted byte, the engine holds SDA low for the ninth SCL clock. It releases SDA after the falling edge of that clock.
- R5: In a write, the second byte loads address bits [7:0] and is acknowledged. Each later data byte is acknowledged and produces one `wr_stb_o` pulse, carrying the current address and the byte.
- R6: During writes the counter advances only in its low 4 bits, so a 16-byte page wraps onto itself.
- R7: A read that is not preceded by a word address returns the byte at the counter, whose bit 8 is taken from the select byte. The counter always holds the last accessed address plus one.
- R8: A dummy write that carries a word address, followed by a repeated START and a read select, reads from that word address.
- R9: In a read, a master ACK (SDA low on the ninth clock) makes the engine send the next byte, with a full 9-bit increment that wraps from 511 to 0. A master NACK releases SDA and makes the engine ignore the bus until a START.
- R10: While `mem_busy_i` is high at the eighth bit of the select byte, the select byte is not acknowledged.
- R11: With `wprot_i` high and address bit 8 set, the select and word-address bytes are acknowledged. The first data byte, however, is refused and no write strobe is issued.
- R12: Read data leaves most significant bit first. The engine changes `sda_oe_o` only while the synchronized SCL is low, except when it releases SDA on a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Raw serial clock line |
| sda_i | input | 1 | Raw serial data line as seen on the wire |
| sda_oe_o | output | 1 | Pulls the data line low when high |
| strap_i | input | 2 | Strapped address bits; bit 1 compares with select bit 3, bit 0 with select bit 2 |
| wprot_i | input | 1 | Protects the upper 256 bytes against writes |
| mem_busy_i | input | 1 | Internal write cycle in progress |
| rd_addr_o | output | 9 | Read port address (the counter) |
| rd_data_i | input | 8 | Byte at `rd_addr_o`, valid in the same cycle |
| wr_stb_o | output | 1 | One-cycle byte write strobe |
| wr_addr_o | output | 9 | Write address qualified by `wr_stb_o` |
| wr_data_o | output | 8 | Write data qualified by `wr_stb_o` |
| stop_o | output | 1 | One-cycle pulse on every STOP |

## Verification
The busy input and the select-byte decision can land in the same cycle. The engine looks at busy only at the eighth select bit, so a write cycle that ends while that byte is in flight decides whether the master is acknowledged. The bench holds busy high through the first seven bits, drops it just before the eighth rising clock, and expects an ACK. In a separate transaction it keeps busy high throughout and expects a NACK. It then confirms that the word address sent after the ACKed select byte became the new read pointer.

// File: rtl/eeps_pkg.sv
package eeps_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = BYTE_W + 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } eng_state_e;

  typedef enum logic [1:0] {
    K_DEV,
    K_WADDR,
    K_WDATA
  } rx_kind_e;
endpackage

// File: rtl/eeps_sync.sv
module eeps_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[g] <= 1'b1;
        stab_q[g] <= 1'b1;
      end else begin
        meta_q[g] <= d_i[g];
        stab_q[g] <= meta_q[g];
      end
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/eeps_bus_cond.sv
module eeps_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  // Conditions need SCL high on both samples; edges need it to change.
  assign start_o = scl_q & scl_s & sda_q & ~sda_s;
  assign stop_o  = scl_q & scl_s & ~sda_q & sda_s;
  assign rise_o  = ~scl_q & scl_s;
  assign fall_o  = scl_q & ~scl_s;
endmodule

// File: rtl/eeps_ctrl.sv
module eeps_ctrl
  import eeps_pkg::*;
#(
  parameter int          PAGE_W   = 4,
  parameter logic [3:0]  DEV_TYPE = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              cond_start,
  input  logic              cond_stop,
  input  logic [1:0]        strap_i,
  input  logic              wprot_i,
  input  logic              busy_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              wr_stb_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              sda_oe_o
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [PAGE_W-1:0] PG_ONE  = PAGE_W'(1);
  localparam logic [ADDR_W-1:0] AD_ONE  = ADDR_W'(1);

  eng_state_e        st_q, st_d;
  rx_kind_e          kind_q, kind_d;
  logic [BYTE_W-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              done_q, done_d;
  logic              ack_q, ack_d;
  logic              rw_q, rw_d;
  logic              oe_q, oe_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              wstb_q, wstb_d;
  logic [ADDR_W-1:0] waddr_q, waddr_d;
  logic [BYTE_W-1:0] wdat_q, wdat_d;

  logic [BYTE_W-1:0] nb;
  logic              dev_hit;
  logic              prot;
  logic [ADDR_W-1:0] addr_inc;
  logic [ADDR_W-1:0] addr_pg;

  assign nb       = {sr_q[BYTE_W-2:0], sda_s};
  assign dev_hit  = (nb[7:4] == DEV_TYPE) && (nb[3:2] == strap_i) && !busy_i;
  assign prot     = wprot_i && addr_q[ADDR_W-1];
  assign addr_inc = addr_q + AD_ONE;
  assign addr_pg  = {addr_q[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0] + PG_ONE};

  always_comb begin
    st_d    = st_q;
    kind_d  = kind_q;
    sr_d    = sr_q;
    cnt_d   = cnt_q;
    done_d  = done_q;
    ack_d   = ack_q;
    rw_d    = rw_q;
    oe_d    = oe_q;
    addr_d  = addr_q;
    wstb_d  = 1'b0;
    waddr_d = waddr_q;
    wdat_d  = wdat_q;
    if (cond_start) begin
      st_d   = ST_RX;
      kind_d = K_DEV;
      cnt_d  = '0;
      done_d = 1'b0;
      oe_d   = 1'b0;
    end else if (cond_stop) begin
      st_d   = ST_IDLE;
      done_d = 1'b0;
      oe_d   = 1'b0;
    end else begin
      case (st_q)
        ST_RX: begin
          if (scl_rise) begin
            sr_d  = nb;
            cnt_d = cnt_q + CNT_ONE;
            if (cnt_q == CNT_LAST) begin
              done_d = 1'b1;
              case (kind_q)
                K_DEV: begin
                  ack_d = dev_hit;
                  if (dev_hit) begin
                    addr_d[ADDR_W-1] = nb[1];
                    rw_d             = nb[0];
                  end
                end
                K_WADDR: begin
                  ack_d               = 1'b1;
                  addr_d[BYTE_W-1:0]  = nb;
                end
                default: begin
                  ack_d = !prot;
                  if (!prot) begin
                    wstb_d  = 1'b1;
                    waddr_d = addr_q;
                    wdat_d  = nb;
                    addr_d  = addr_pg;
                  end
                end
              endcase
            end
          end else if (scl_fall && done_q) begin
            done_d = 1'b0;
            if (ack_q) begin
              oe_d = 1'b1;
              st_d = ST_RX_ACK;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (kind_q == K_DEV && rw_q) begin
              st_d   = ST_TX;
              oe_d   = !rd_data_i[BYTE_W-1];
              sr_d   = {rd_data_i[BYTE_W-2:0], 1'b0};
              addr_d = addr_inc;
            end else begin
              oe_d   = 1'b0;
              st_d   = ST_RX;
              kind_d = (kind_q == K_DEV) ? K_WADDR : K_WDATA;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            cnt_d = cnt_q + CNT_ONE;
            if (cnt_q == CNT_LAST) done_d = 1'b1;
          end else if (scl_fall) begin
            if (done_q) begin
              done_d = 1'b0;
              oe_d   = 1'b0;
              st_d   = ST_TX_ACK;
            end else begin
              oe_d = !sr_q[BYTE_W-1];
              sr_d = {sr_q[BYTE_W-2:0], 1'b0};
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            ack_d  = !sda_s;
            done_d = 1'b1;
          end else if (scl_fall && done_q) begin
            done_d = 1'b0;
            cnt_d  = '0;
            if (ack_q) begin
              st_d   = ST_TX;
              oe_d   = !rd_data_i[BYTE_W-1];
              sr_d   = {rd_data_i[BYTE_W-2:0], 1'b0};
              addr_d = addr_inc;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      kind_q  <= K_DEV;
      sr_q    <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      ack_q   <= 1'b0;
      rw_q    <= 1'b0;
      oe_q    <= 1'b0;
      addr_q  <= '0;
      wstb_q  <= 1'b0;
      waddr_q <= '0;
      wdat_q  <= '0;
    end else begin
      st_q    <= st_d;
      kind_q  <= kind_d;
      sr_q    <= sr_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
      ack_q   <= ack_d;
      rw_q    <= rw_d;
      oe_q    <= oe_d;
      addr_q  <= addr_d;
      wstb_q  <= wstb_d;
      waddr_q <= waddr_d;
      wdat_q  <= wdat_d;
    end
  end

  assign rd_addr_o = addr_q;
  assign wr_stb_o  = wstb_q;
  assign wr_addr_o = waddr_q;
  assign wr_data_o = wdat_q;
  assign sda_oe_o  = oe_q;

  // R2: idle never pulls the line
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> !oe_q);

  // R1: a START leaves the line released and bit counting from zero
  a_r1_start_restart: assert property (@(posedge clk) disable iff (!rst_n)
    cond_start |=> (!oe_q && st_q == ST_RX && cnt_q == '0));

  // R5: write strobe lasts one cycle
  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    wstb_q |=> !wstb_q);

  // R11: no strobe into the protected half
  a_r11_no_protected_write: assert property (@(posedge clk) disable iff (!rst_n)
    wstb_q |-> !($past(wprot_i) && waddr_q[ADDR_W-1]));

  // R9: each byte sent advances the full counter by one
  a_r9_read_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TX && $past(st_q) != ST_TX) |-> (addr_q == $past(addr_q) + AD_ONE));
endmodule

// File: rtl/eeprom_bus_slave.sv
module eeprom_bus_slave
  import eeps_pkg::*;
#(
  parameter int         PAGE_W   = 4,
  parameter logic [3:0] DEV_TYPE = 4'b1010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [1:0]        strap_i,
  input  logic              wprot_i,
  input  logic              mem_busy_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              wr_stb_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              stop_o
);
  logic       rst_meta_q;
  logic       rst_n;
  logic [1:0] line_s;
  logic       scl_s;
  logic       sda_s;
  logic       c_start;
  logic       c_stop;
  logic       c_rise;
  logic       c_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_n      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n      <= rst_meta_q;
    end
  end

  eeps_sync #(.W(2)) u_sync (
    .clk   (clk_i),
    .rst_n (rst_n),
    .d_i   ({scl_i, sda_i}),
    .q_o   (line_s)
  );
  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  eeps_bus_cond u_cond (
    .clk     (clk_i),
    .rst_n   (rst_n),
    .scl_s   (scl_s),
    .sda_s   (sda_s),
    .start_o (c_start),
    .stop_o  (c_stop),
    .rise_o  (c_rise),
    .fall_o  (c_fall)
  );

  eeps_ctrl #(.PAGE_W(PAGE_W), .DEV_TYPE(DEV_TYPE)) u_ctrl (
    .clk        (clk_i),
    .rst_n      (rst_n),
    .sda_s      (sda_s),
    .scl_rise   (c_rise),
    .scl_fall   (c_fall),
    .cond_start (c_start),
    .cond_stop  (c_stop),
    .strap_i    (strap_i),
    .wprot_i    (wprot_i),
    .busy_i     (mem_busy_i),
    .rd_addr_o  (rd_addr_o),
    .rd_data_i  (rd_data_i),
    .wr_stb_o   (wr_stb_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o),
    .sda_oe_o   (sda_oe_o)
  );

  assign stop_o = c_stop;

  // R12: the slave moves the line only in the SCL low phase
  a_r12_drive_low_phase: assert property (@(posedge clk_i) disable iff (!rst_n)
    (sda_oe_o != $past(sda_oe_o)) |-> (!scl_s || $past(c_start || c_stop)));
endmodule

// File: tb/eeprom_bus_slave_tb_top.sv
module eeprom_bus_slave_tb_top;
  localparam int Q = 4;
  localparam logic [1:0] STRAP = 2'b10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       m_scl;
  logic       m_sda_low;
  logic       sda_line;
  logic       sda_oe;
  logic       wp;
  logic       busy;
  logic [8:0] rd_addr;
  logic [7:0] rd_data;
  logic       wr_stb;
  logic [8:0] wr_addr;
  logic [7:0] wr_data;
  logic       stop_p;

  logic [7:0] mem     [512];
  logic [7:0] ref_mem [512];
  logic [8:0] ref_ptr;
  int checks = 0;
  int errors = 0;
  int oe_hi = 0;
  int stop_cnt = 0;
  int stb_cnt = 0;
  int exp_stb = 0;

  always #4 clk = ~clk;

  assign sda_line = !(m_sda_low || sda_oe);
  assign rd_data  = mem[rd_addr];

  eeprom_bus_slave dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .scl_i      (m_scl),
    .sda_i      (sda_line),
    .sda_oe_o   (sda_oe),
    .strap_i    (STRAP),
    .wprot_i    (wp),
    .mem_busy_i (busy),
    .rd_addr_o  (rd_addr),
    .rd_data_i  (rd_data),
    .wr_stb_o   (wr_stb),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data),
    .stop_o     (stop_p)
  );

  always @(posedge clk) if (wr_stb) mem[wr_addr] <= wr_data;

  always @(negedge clk) begin
    if (sda_oe) oe_hi++;
    if (stop_p) stop_cnt++;
    if (wr_stb) stb_cnt++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] dev_b(input logic p, input logic rw);
    return {4'b1010, STRAP, p, rw};
  endfunction

  task automatic bus_start();
    m_sda_low = 1'b0; wq(Q);
    m_scl = 1'b1;     wq(Q);
    m_sda_low = 1'b1; wq(Q);
    m_scl = 1'b0;     wq(Q);
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1; wq(Q);
    m_scl = 1'b1;     wq(Q);
    m_sda_low = 1'b0; wq(Q);
  endtask

  task automatic put_bit(input logic b);
    m_sda_low = !b; wq(Q);
    m_scl = 1'b1;   wq(2 * Q);
    m_scl = 1'b0;   wq(Q);
  endtask

  task automatic get_bit(output logic b);
    m_sda_low = 1'b0; wq(Q);
    m_scl = 1'b1;     wq(Q);
    b = sda_line;     wq(Q);
    m_scl = 1'b0;     wq(Q);
  endtask

  task automatic tx_byte(input logic [7:0] b, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(x);
    ack = !x;
  endtask

  task automatic rx_byte(input logic give_ack, output logic [7:0] b);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      get_bit(x);
      b[i] = x;
    end
    put_bit(!give_ack);
  endtask

  task automatic cmp_mem(input string tag);
    int bad = 0;
    for (int i = 0; i < 512; i++) if (mem[i] !== ref_mem[i]) bad++;
    chk(tag, bad, 0);
  endtask

  task automatic do_write(input logic p, input logic [7:0] a, input int n);
    logic ak;
    logic [7:0] d;
    logic prot_e;
    logic [8:0] ptr;
    prot_e = wp && p;
    bus_start();
    tx_byte(dev_b(p, 1'b0), ak); chk("R3 R4 write select ack", ak, 1);
    tx_byte(a, ak);              chk("R5 word address ack", ak, 1);
    ptr = {p, a};
    ref_ptr = ptr;
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      tx_byte(d, ak);
      chk(prot_e ? "R11 protected data nack" : "R5 data ack", ak, !prot_e);
      if (prot_e) break;
      ref_mem[ptr] = d;
      exp_stb++;
      ptr = {ptr[8:4], ptr[3:0] + 4'd1};
      ref_ptr = ptr;
    end
    bus_stop();
  endtask

  task automatic read_n(input int n, input string tag);
    logic [7:0] b;
    for (int k = 0; k < n; k++) begin
      rx_byte(k != n - 1, b);
      chk(tag, b, ref_mem[ref_ptr]);
      ref_ptr = ref_ptr + 9'd1;
    end
    wq(2);
    chk("R9 line released after master nack", sda_oe, 0);
  endtask

  task automatic do_read_rand(input logic p, input logic [7:0] a, input int n, input string tag);
    logic ak;
    bus_start();
    tx_byte(dev_b(p, 1'b0), ak); chk("R8 dummy write select ack", ak, 1);
    tx_byte(a, ak);              chk("R8 dummy word address ack", ak, 1);
    bus_start();
    tx_byte(dev_b(p, 1'b1), ak); chk("R8 read select ack", ak, 1);
    ref_ptr = {p, a};
    read_n(n, tag);
    bus_stop();
  endtask

  task automatic do_read_cur(input logic p, input int n);
    logic ak;
    bus_start();
    tx_byte(dev_b(p, 1'b1), ak); chk("R7 current read select ack", ak, 1);
    ref_ptr[8] = p;
    read_n(n, "R7 current address read");
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic ak;
    int base;
    int sbase;
    int seed;
    m_scl = 1'b1; m_sda_low = 1'b0; wp = 1'b0; busy = 1'b0; rst_n = 1'b0;
    ref_ptr = '0;
    for (int i = 0; i < 512; i++) begin
      mem[i]     = 8'(i * 37 + 5);
      ref_mem[i] = 8'(i * 37 + 5);
    end
    seed = $urandom(32'd4242);
    wq(5); rst_n = 1'b1; wq(6);

    chk("R2 reset sda_oe", sda_oe, 0);
    chk("R5 reset wr_stb", wr_stb, 0);
    chk("R1 reset stop_o", stop_p, 0);

    // R2: a matching select byte without START draws no reaction
    m_scl = 1'b0; wq(Q);
    base = oe_hi;
    for (int i = 7; i >= 0; i--) put_bit(dev_b(1'b0, 1'b0)[i]);
    get_bit(ak);
    chk("R2 no ack before START", oe_hi, base);
    base = stop_cnt;
    bus_stop();
    wq(2);
    chk("R1 stop pulse count", stop_cnt, base + 1);

    // R3: wrong device type, then wrong strap; following bytes ignored
    bus_start();
    tx_byte(8'b1011_1000, ak); chk("R3 wrong type nack", ak, 0);
    tx_byte(8'h00, ak);        chk("R3 ignored until START", ak, 0);
    bus_stop();
    bus_start();
    tx_byte({4'b1010, ~STRAP, 2'b00}, ak); chk("R3 wrong strap nack", ak, 0);
    bus_stop();

    // R5 byte write, R6 page wrap
    do_write(1'b0, 8'h10, 1);
    cmp_mem("R5 byte write content");
    do_write(1'b1, 8'h3C, 20);
    cmp_mem("R6 page write wraps in page");
    chk("R5 strobe count", stb_cnt, exp_stb);

    // R8 random read, R9 R12 sequential wrap 511 -> 0
    do_read_rand(1'b1, 8'h3A, 5, "R8 R12 random read data");
    do_read_rand(1'b1, 8'hFD, 6, "R9 sequential read wrap");
    do_read_cur(1'b0, 3);
    do_read_cur(1'b1, 2);

    // R11 protection
    wp = 1'b1;
    sbase = stb_cnt;
    do_write(1'b1, 8'h20, 3);
    wq(2);
    chk("R11 no strobe when protected", stb_cnt, sbase);
    do_write(1'b0, 8'h21, 2);
    cmp_mem("R11 lower half still writable");
    wp = 1'b0;
    do_read_cur(1'b0, 1);

    // R10 busy refuses select byte
    busy = 1'b1;
    bus_start();
    tx_byte(dev_b(1'b0, 1'b0), ak); chk("R10 busy nack", ak, 0);
    bus_stop();
    // R10 busy released just before eighth select bit
    bus_start();
    for (int i = 7; i >= 1; i--) put_bit(dev_b(1'b1, 1'b0)[i]);
    busy = 1'b0;
    put_bit(1'b0);
    get_bit(ak); ak = !ak;
    chk("R10 busy released before decision ack", ak, 1);
    tx_byte(8'h77, ak); chk("R5 word address ack after busy", ak, 1);
    bus_stop();
    ref_ptr = 9'h177;
    do_read_cur(1'b1, 2);

    // R1 START mid byte aborts and restarts cleanly
    bus_start();
    tx_byte(dev_b(1'b0, 1'b0), ak); chk("R1 select before abort", ak, 1);
    tx_byte(8'h55, ak);             chk("R1 address before abort", ak, 1);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    do_write(1'b0, 8'h90, 2);
    cmp_mem("R1 write after aborted byte");

    // constrained random mix
    for (int it = 0; it < 30; it++) begin
      int op;
      op = $urandom % 3;
      wp = 1'($urandom);
      if (op == 0) do_write(1'($urandom), 8'($urandom), 1 + $urandom % 10);
      else if (op == 1) do_read_rand(1'($urandom), 8'($urandom), 1 + $urandom % 6, "R9 random sequential read");
      else do_read_cur(1'($urandom), 1 + $urandom % 4);
    end
    wp = 1'b0;
    wq(4);
    cmp_mem("R5 R6 final memory image");
    chk("R5 final strobe count", stb_cnt, exp_stb);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule